// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a parallel port of general-purpose pins that a processor controls through a small synchronous register bus. The bus has a word address, a write strobe, write data and registered read data. Each line has three pin signals: an output value, an output enable and an input. The number of lines equals the register width, which can be 8, 16, 32 or 64 bits. Any other width, or any illegal combination of options, stops elaboration.

Build-time parameters choose how software changes the outputs. In the data-only model, the data word is written directly. In the set-plus-data model, the set word holds the whole output value. In the set/clear model, one word raises lines and another lowers them. The direction word is optional. When it is present, a 1 in it means either "output" or "input", as a parameter selects. A mirrored bit order can be enabled, as can a byte swap on the bus for 16- and 32-bit ports. An option makes the set word read back the driven output values. A no-output variant turns the port into a pure input port.

Input pins pass through a two-stage synchroniser before software can read them. The bus has no back-pressure and no handshake: every write is accepted on the edge that samples it, and every address is answered one cycle later.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output latch is zero and every line is an input. For ports with a direction word, every output enable is 0 and read data is 0.
- R2: In the data-only model, a write to word 0 (data) loads all output lines at once. `pin_out` shows the new value after the edge that samples the write.
- R3: In the set/clear model, each 1 in a write to word 1 (set) drives that line high, and each 1 in a write to word 2 (clear) drives that line low. Zero bits leave their lines unchanged. Writes to word 0 have no effect on the outputs.
- R4: In the set-plus-data model, a write to word 1 replaces the whole output value: a 1 drives the line high and a 0 drives it low. Writes to word 0 have no effect on the outputs.
- R5: Word 3 holds the direction. With the output-high polarity, a 1 makes the line an output (`pin_oe` = 1). With the input-high polarity, a 1 makes the line an input (`pin_oe` = 0). Reading word 3 returns the stored value.
- R6: Without a direction word, every output enable is 1 at all times. Word 3 reads 0 and ignores writes. Word 0 reads the synchronised pins.
- R7: With mirroring, line n corresponds to register bit WIDTH-1-n. This applies in every word, for both reads and writes.
- R8: With byte swap on a 16- or 32-bit port, bus byte k corresponds to register byte (WIDTH/8)-1-k, in both directions. The swap is applied together with mirroring.
- R9: A read of word 0 returns the latched value on output lines and the synchronised pin value on input lines. A pin change first appears in read data on the third rising edge after the change.
- R10: When read-output-through-set is enabled, word 1 reads the latched value masked by the output enables. Otherwise word 1 reads 0. Word 2 always reads 0.
- R11: In no-output mode, writes to words 0, 1 and 2 leave `pin_out` unchanged, every output enable stays 0, and word 0 reads the synchronised pins.
- R12: Read data is registered and answers the address presented one cycle earlier. If a read and a write address the same word in the same cycle, the read returns the value from before the write. `pin_out` does not change in a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word select: 0 data, 1 set, 2 clear, 3 direction |
| bus_wr_en | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | WIDTH | Write data in bus order |
| bus_rdata | output | WIDTH | Registered read data in bus order |
| pin_in | input | WIDTH | Asynchronous pin inputs, indexed by line |
| pin_out | output | WIDTH | Output values, indexed by line |
| pin_oe | output | WIDTH | Output enables, indexed by line |

## Verification
A read and a write can land in the same cycle, because the read address is also the write address. The bench writes the set word while addressing it. It expects the registered read data to show the pre-write output value, while `pin_out` already shows the new value, and the new value to appear in read data one cycle later. A pin change is also raised while an input line is being read continuously. The read data is checked on the second edge, where it must still hold the old value, and on the third, where it must hold the new one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_DIR  = 2'd3
  } gpio_word_e;

  localparam int MODEL_DATA    = 0;
  localparam int MODEL_SETDATA = 1;
  localparam int MODEL_SETCLR  = 2;

  localparam int DIR_NONE    = 0;
  localparam int DIR_OUT_HI  = 1;
  localparam int DIR_IN_HI   = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
  parameter int WIDTH     = 32,
  parameter int MIRROR    = 0,
  parameter int BYTE_SWAP = 0,
  parameter int TO_LINES  = 1
) (
  input  logic [WIDTH-1:0] vec_in,
  output logic [WIDTH-1:0] vec_out
);
  localparam int NBYTES = WIDTH / 8;

  function automatic logic [WIDTH-1:0] swap_bytes(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (BYTE_SWAP != 0) begin
      for (int k = 0; k < NBYTES; k++)
        for (int j = 0; j < 8; j++)
          r[8*k + j] = v[8*(NBYTES-1-k) + j];
    end
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] mirror_bits(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (MIRROR != 0) begin
      for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    end
    return r;
  endfunction

  generate
    if (TO_LINES != 0) begin : g_bus_to_line
      assign vec_out = mirror_bits(swap_bytes(vec_in));
    end else begin : g_line_to_bus
      assign vec_out = swap_bytes(mirror_bits(vec_in));
    end
  endgenerate
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int MODEL     = MODEL_SETCLR,
  parameter int DIR_MODE  = DIR_OUT_HI,
  parameter int NO_OUTPUT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpio_word_e       sel,
  input  logic [WIDTH-1:0] wr_line,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] oe
);
  localparam logic [WIDTH-1:0] DIR_RST = (DIR_MODE == DIR_IN_HI) ? '1 : '0;
  localparam bit OUT_OK = (NO_OUTPUT == 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= DIR_RST;
    end else if (wr_en) begin
      unique case (sel)
        SEL_DATA: begin
          if (OUT_OK && MODEL == MODEL_DATA) out_q <= wr_line;
        end
        SEL_SET: begin
          if (OUT_OK && MODEL == MODEL_SETDATA) out_q <= wr_line;
          else if (OUT_OK && MODEL == MODEL_SETCLR) out_q <= out_q | wr_line;
        end
        SEL_CLR: begin
          if (OUT_OK && MODEL == MODEL_SETCLR) out_q <= out_q & ~wr_line;
        end
        SEL_DIR: begin
          if (DIR_MODE != DIR_NONE) dir_q <= wr_line;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (!OUT_OK)                   oe = '0;
    else if (DIR_MODE == DIR_NONE) oe = '1;
    else if (DIR_MODE == DIR_OUT_HI) oe = dir_q;
    else                           oe = ~dir_q;
  end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int MODEL        = MODEL_SETCLR,
  parameter int DIR_MODE     = DIR_OUT_HI,
  parameter int READ_SET_OUT = 1
) (
  input  gpio_word_e       sel,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] oe,
  input  logic [WIDTH-1:0] sync_in,
  output logic [WIDTH-1:0] rd_line
);
  always_comb begin
    unique case (sel)
      SEL_DATA: begin
        if (DIR_MODE == DIR_NONE) rd_line = sync_in;
        else                      rd_line = (oe & out_q) | (~oe & sync_in);
      end
      SEL_SET: begin
        if (READ_SET_OUT != 0 && MODEL != MODEL_DATA) rd_line = out_q & oe;
        else                                          rd_line = '0;
      end
      SEL_DIR: begin
        if (DIR_MODE != DIR_NONE) rd_line = dir_q;
        else                      rd_line = '0;
      end
      default: rd_line = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int MODEL        = MODEL_SETCLR,
  parameter int DIR_MODE     = DIR_OUT_HI,
  parameter int MIRROR       = 0,
  parameter int BYTE_SWAP    = 0,
  parameter int READ_SET_OUT = 1,
  parameter int NO_OUTPUT    = 0,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr_en,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  localparam bit WIDTH_OK = (WIDTH == 8) || (WIDTH == 16) || (WIDTH == 32) || (WIDTH == 64);
  localparam bit SWAP_OK  = (BYTE_SWAP == 0) || (WIDTH == 16) || (WIDTH == 32);

  generate
    if (!WIDTH_OK) begin : g_bad_width
      $error("gpio_port: WIDTH must be 8, 16, 32 or 64");
    end
    if (!SWAP_OK) begin : g_bad_swap
      $error("gpio_port: byte swap needs WIDTH 16 or 32");
    end
    if (MODEL > MODEL_SETCLR || DIR_MODE > DIR_IN_HI) begin : g_bad_mode
      $error("gpio_port: unknown register model or direction polarity");
    end
  endgenerate

  gpio_word_e       word_sel;
  logic [WIDTH-1:0] wr_line;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] oe;
  logic [WIDTH-1:0] sync_in;
  logic [WIDTH-1:0] rd_line;
  logic [WIDTH-1:0] rd_bus;
  logic [WIDTH-1:0] rdata_q;

  assign word_sel = gpio_word_e'(bus_addr);

  gpio_lane_map #(
    .WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP), .TO_LINES(1)
  ) u_wmap (
    .vec_in(bus_wdata), .vec_out(wr_line)
  );

  gpio_out_regs #(
    .WIDTH(WIDTH), .MODEL(MODEL), .DIR_MODE(DIR_MODE), .NO_OUTPUT(NO_OUTPUT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .sel(word_sel),
    .wr_line(wr_line), .out_q(out_q), .dir_q(dir_q), .oe(oe)
  );

  gpio_sync #(
    .WIDTH(WIDTH), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(sync_in)
  );

  gpio_readback #(
    .WIDTH(WIDTH), .MODEL(MODEL), .DIR_MODE(DIR_MODE), .READ_SET_OUT(READ_SET_OUT)
  ) u_rdbk (
    .sel(word_sel), .out_q(out_q), .dir_q(dir_q), .oe(oe),
    .sync_in(sync_in), .rd_line(rd_line)
  );

  gpio_lane_map #(
    .WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP), .TO_LINES(0)
  ) u_rmap (
    .vec_in(rd_line), .vec_out(rd_bus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_bus;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = oe;
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
  import gpio_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int MODEL     = MODEL_SETCLR,
  parameter int DIR_MODE  = DIR_OUT_HI,
  parameter int NO_OUTPUT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr_en,
  input logic [WIDTH-1:0] wr_line,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe
);
  localparam bit SC  = (MODEL == MODEL_SETCLR) && (NO_OUTPUT == 0);
  localparam bit DOH = (DIR_MODE == DIR_OUT_HI) && (NO_OUTPUT == 0);
  localparam bit DIH = (DIR_MODE == DIR_IN_HI) && (NO_OUTPUT == 0);
  localparam bit NOO = (NO_OUTPUT != 0);

  // R12: the latch only moves on a write
  assert_latch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(pin_out));

  // R3: set word raises every masked line
  assert_set_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (SC && bus_wr_en && bus_addr == 2'd1) |=>
      ((pin_out & $past(wr_line)) == $past(wr_line)));

  // R3: clear word lowers every masked line
  assert_clr_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (SC && bus_wr_en && bus_addr == 2'd2) |=>
      ((pin_out & $past(wr_line)) == '0));

  // R3: unmasked lines keep their level
  assert_unmasked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (SC && bus_wr_en && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=>
      ((pin_out & ~$past(wr_line)) == ($past(pin_out) & ~$past(wr_line))));

  // R5: output-high polarity
  assert_dir_out_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (DOH && bus_wr_en && bus_addr == 2'd3) |=> (pin_oe == $past(wr_line)));

  // R5: input-high polarity
  assert_dir_in_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (DIH && bus_wr_en && bus_addr == 2'd3) |=> (pin_oe == ~$past(wr_line)));

  // R11: input-only port never drives
  assert_quiet_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (NOO && bus_wr_en) |=> ($stable(pin_out) && pin_oe == '0));
endmodule

bind gpio_port gpio_port_checker #(
  .WIDTH(WIDTH), .MODEL(MODEL), .DIR_MODE(DIR_MODE), .NO_OUTPUT(NO_OUTPUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .wr_line(wr_line), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [63:0] bus_wdata = '0;
  logic        wr_a = 1'b0, wr_b = 1'b0, wr_c = 1'b0, wr_d = 1'b0;
  logic [31:0] rd_a, pin_in_a = '0, out_a, oe_a;
  logic [15:0] rd_b, pin_in_b = '0, out_b, oe_b;
  logic [7:0]  rd_c, pin_in_c = '0, out_c, oe_c;
  logic [7:0]  rd_d, pin_in_d = '0, out_d, oe_d;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // A: 32-bit set/clear, 1=output, set readback
  gpio_port #(.WIDTH(32), .MODEL(2), .DIR_MODE(1), .MIRROR(0), .BYTE_SWAP(0),
              .READ_SET_OUT(1), .NO_OUTPUT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(wr_a),
    .bus_wdata(bus_wdata[31:0]), .bus_rdata(rd_a), .pin_in(pin_in_a),
    .pin_out(out_a), .pin_oe(oe_a));

  // B: 16-bit set-plus-data, 1=input, mirrored, byte swapped
  gpio_port #(.WIDTH(16), .MODEL(1), .DIR_MODE(2), .MIRROR(1), .BYTE_SWAP(1),
              .READ_SET_OUT(0), .NO_OUTPUT(0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(wr_b),
    .bus_wdata(bus_wdata[15:0]), .bus_rdata(rd_b), .pin_in(pin_in_b),
    .pin_out(out_b), .pin_oe(oe_b));

  // C: 8-bit data-only, no direction word
  gpio_port #(.WIDTH(8), .MODEL(0), .DIR_MODE(0), .MIRROR(0), .BYTE_SWAP(0),
              .READ_SET_OUT(0), .NO_OUTPUT(0)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(wr_c),
    .bus_wdata(bus_wdata[7:0]), .bus_rdata(rd_c), .pin_in(pin_in_c),
    .pin_out(out_c), .pin_oe(oe_c));

  // D: 8-bit input-only port
  gpio_port #(.WIDTH(8), .MODEL(0), .DIR_MODE(1), .MIRROR(0), .BYTE_SWAP(0),
              .READ_SET_OUT(0), .NO_OUTPUT(1)) u_dut_d (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(wr_d),
    .bus_wdata(bus_wdata[7:0]), .bus_rdata(rd_d), .pin_in(pin_in_d),
    .pin_out(out_d), .pin_oe(oe_d));

  // R7 + R8 on a 16-bit port: swap bytes, then reverse all bits (self-inverse)
  function automatic logic [15:0] map16(input logic [15:0] v);
    logic [15:0] s, r;
    s = {v[7:0], v[15:8]};
    for (int i = 0; i < 16; i++) r[i] = s[15-i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int which, input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    case (which)
      0: wr_a = 1'b1;
      1: wr_b = 1'b1;
      2: wr_c = 1'b1;
      default: wr_d = 1'b1;
    endcase
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0; wr_c = 1'b0; wr_d = 1'b0;
  endtask

  task automatic bus_select(input logic [1:0] a);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset pin_out A", 64'(out_a), 64'h0);
    check("R1 reset oe A", 64'(oe_a), 64'h0);
    check("R1 reset rdata A", 64'(rd_a), 64'h0);
    check("R1 reset oe B (input-high)", 64'(oe_b), 64'h0);
    check("R1 reset oe D", 64'(oe_d), 64'h0);
    check("R6 oe C without direction word", 64'(oe_c), 64'hFF);
  endtask

  task automatic t_set_clear;
    bus_write(0, 2'd3, 64'hFFFF_FFFF);
    check("R5 output-high all outputs", 64'(oe_a), 64'hFFFF_FFFF);
    bus_write(0, 2'd1, 64'h0000_00F0);
    check("R3 set F0", 64'(out_a), 64'hF0);
    bus_write(0, 2'd1, 64'h0000_0003);
    check("R3 set adds 03", 64'(out_a), 64'hF3);
    bus_write(0, 2'd2, 64'h0000_0030);
    check("R3 clear 30", 64'(out_a), 64'hC3);
    bus_write(0, 2'd0, 64'hFFFF_FFFF);
    check("R3 data word write ignored", 64'(out_a), 64'hC3);
  endtask

  task automatic t_readback;
    bus_write(0, 2'd3, 64'h0000_FFFF);
    check("R5 upper half inputs", 64'(oe_a), 64'h0000_FFFF);
    @(negedge clk); pin_in_a = 32'hAAAA_5555;
    repeat (3) @(negedge clk);
    bus_select(2'd0);
    check("R9 mixed data read", 64'(rd_a), 64'hAAAA_00C3);
    bus_select(2'd1);
    check("R10 set word readback", 64'(rd_a), 64'h0000_00C3);
    bus_select(2'd2);
    check("R10 clear word reads zero", 64'(rd_a), 64'h0);
    bus_select(2'd3);
    check("R5 direction readback", 64'(rd_a), 64'h0000_FFFF);
  endtask

  task automatic t_sync_latency;
    bus_select(2'd0);
    pin_in_a = 32'h5555_0000;
    repeat (2) @(negedge clk);
    check("R9 pin not yet visible after 2 edges", 64'(rd_a), 64'hAAAA_00C3);
    @(negedge clk);
    check("R9 pin visible after 3 edges", 64'(rd_a), 64'h5555_00C3);
  endtask

  task automatic t_same_cycle;
    bus_select(2'd1);
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 64'h100; wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0;
    check("R12 read in write cycle returns old value", 64'(rd_a), 64'hC3);
    check("R12 write lands on same edge", 64'(out_a), 64'h1C3);
    @(negedge clk);
    check("R12 new value one cycle later", 64'(rd_a), 64'h1C3);
  endtask

  task automatic t_mirror_swap;
    logic [15:0] exp_rd;
    bus_write(1, 2'd3, 64'h0);
    check("R5 input-high zero makes outputs", 64'(oe_b), 64'hFFFF);
    bus_write(1, 2'd1, 64'h1234);
    check("R4 R7 R8 set loads mapped value", 64'(out_b), 64'(map16(16'h1234)));
    bus_write(1, 2'd1, 64'h0001);
    check("R4 R7 R8 set replaces whole value", 64'(out_b), 64'(map16(16'h0001)));
    bus_write(1, 2'd0, 64'hFFFF);
    check("R4 data word write ignored", 64'(out_b), 64'(map16(16'h0001)));
    bus_write(1, 2'd3, 64'(map16(16'h00FF)));
    check("R5 R7 input-high lines 0-7 inputs", 64'(oe_b), 64'hFF00);
    @(negedge clk); pin_in_b = 16'h00F0;
    repeat (3) @(negedge clk);
    bus_select(2'd0);
    exp_rd = map16((map16(16'h0001) & 16'hFF00) | (16'h00F0 & 16'h00FF));
    check("R7 R8 R9 mapped data read", 64'(rd_b), 64'(exp_rd));
    bus_select(2'd3);
    check("R7 R8 direction read mapped back", 64'(rd_b), 64'(map16(16'h00FF)));
    bus_select(2'd1);
    check("R10 set word unreadable", 64'(rd_b), 64'h0);
  endtask

  task automatic t_data_only;
    bus_write(2, 2'd0, 64'h5A);
    check("R2 data load 5A", 64'(out_c), 64'h5A);
    bus_write(2, 2'd0, 64'hA5);
    check("R2 data load A5", 64'(out_c), 64'hA5);
    bus_write(2, 2'd3, 64'hFF);
    check("R6 oe unaffected by direction write", 64'(oe_c), 64'hFF);
    bus_select(2'd3);
    check("R6 direction word reads zero", 64'(rd_c), 64'h0);
    @(negedge clk); pin_in_c = 8'h3C;
    repeat (3) @(negedge clk);
    bus_select(2'd0);
    check("R6 data reads pins", 64'(rd_c), 64'h3C);
  endtask

  task automatic t_no_output;
    bus_write(3, 2'd3, 64'hFF);
    check("R11 oe stays low", 64'(oe_d), 64'h0);
    bus_write(3, 2'd0, 64'hFF);
    check("R11 data write ignored", 64'(out_d), 64'h0);
    @(negedge clk); pin_in_d = 8'h81;
    repeat (3) @(negedge clk);
    bus_select(2'd0);
    check("R11 pins readable", 64'(rd_d), 64'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_readback();
    t_sync_latency();
    t_same_cycle();
    t_mirror_swap();
    t_data_only();
    t_no_output();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule